// File: doc/BRIEF.md
# Shared Recirculating Multiply/Divide Unit

This block is the integer multiply/divide engine that several hardware threads share. It holds a single 32x32 multiplier array and a 64-bit restoring divider. A multiply whose operands are both 32 bits passes through the array in one pipelined step and returns its result on the next cycle. A multiply on 64-bit operands, and every divide, stays inside the unit and iterates for a fixed number of cycles. While it does so the unit reports itself busy.

Issue logic may present a new operation on any cycle. An operation offered while the unit is recirculating does not stall. It is rejected at once with a flush indication, and the issuing thread replays it later. The operation that owns the unit runs on to completion. Each result leaves the unit with a one-cycle valid pulse that carries the thread ID of the operation that produced it. All arithmetic is unsigned. A divide by zero is not reported as an error: it finishes in its normal time and returns a fixed pattern.

Top module: `muldiv_unit`

## Requirements
- R1: A multiply with `issueWide`=0 (`issueIsDiv`=0 selects multiply) accepted in cycle T returns `resValid`=1 in cycle T+1 with `resData` = unsigned product of the low 32 bits of both operands (64 bits), and `busy` stays 0.
- R2: A multiply with `issueWide`=1 holds `busy` high for 4 cycles (T+1..T+4) and raises `resValid` in cycle T+4 with `resData` = low 64 bits of the unsigned 64x64 product.
- R3: A divide (`issueIsDiv`=1) with `issueWide`=1 holds `busy` high for 65 cycles and raises `resValid` in the last of them with `resData` = unsigned quotient and `resRem` = unsigned remainder.
- R4: A divide with `issueWide`=0 uses only the low 32 bits of both operands, holds `busy` for 32 cycles, and returns quotient and remainder zero-extended to 64 bits in the last busy cycle.
- R5: An issue presented while `busy`=1 raises `issueFlush` in that same cycle. It produces no result, and the operation in flight completes with its own data and thread ID.
- R6: `busy` is high exactly from the cycle after a recirculating issue through the cycle that carries its result. An issue in the following cycle is accepted.
- R7: A divide by zero completes in the normal cycle count with a quotient of all ones (wide: 64 ones; narrow: low 32 bits ones, upper 32 zero) and a remainder equal to the dividend (narrow: its low 32 bits).
- R8: While `resValid`=1, `resThread` equals the `issueThread` of the operation that produced the result.
- R9: After reset, `busy`, `resValid` and `issueFlush` are 0.
- R10: `issueFlush` is 0 in any cycle where `busy`=0 or `issueValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An operation is offered this cycle |
| issueThread | input | THREAD_W | Thread issuing the operation |
| issueIsDiv | input | 1 | 1 = divide, 0 = multiply |
| issueWide | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| issueA | input | WORD_W | Multiplicand or dividend |
| issueB | input | WORD_W | Multiplier or divisor |
| issueFlush | output | 1 | Offered operation collided with a recirculation and is dropped |
| busy | output | 1 | Unit is recirculating |
| resValid | output | 1 | One-cycle result strobe |
| resThread | output | THREAD_W | Owner thread of the result |
| resData | output | WORD_W | Product (low word) or quotient |
| resRem | output | WORD_W | Remainder, meaningful for divides |

## Verification
The bench builds the unit with its default values: a 64-bit word and 2-bit thread IDs. At these values the full 65-cycle wide divide, the 32-cycle narrow divide and the four-pass wide multiply can all be observed, with results tagged for four threads. Random operations are mixed with collisions placed on the first and last busy cycles and with directed cases: divide by zero, all-ones operands, and issues that follow each other with no gap.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // Strobes from the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic       loadAcc;       // start a multiply: first partial product into accumulator
    logic       loadDivWide;   // start a 64-bit divide: load operands only
    logic       loadDivNarrow; // start a 32-bit divide: load and perform first step
    logic       mulStep;       // add the next partial product
    logic       divStep;       // one restoring quotient step
    logic [1:0] mulPhase;      // which partial product the array computes
  } ctrl_strobes_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int THREAD_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [THREAD_W-1:0] issueThread,
  input  logic                issueIsDiv,
  input  logic                issueWide,
  output logic                busy,
  output logic                issueFlush,
  output logic                resValid,
  output logic [THREAD_W-1:0] resThread,
  output logic                resIsDiv,
  output ctrl_strobes_t       strobes
);

  localparam int HALF_W         = WORD_W / 2;
  localparam int DIV_WIDE_CYC   = WORD_W + 1;
  localparam int DIV_NARROW_CYC = HALF_W;
  localparam int MUL_WIDE_CYC   = 4;
  localparam int CNT_W          = $clog2(DIV_WIDE_CYC + 1);

  localparam logic [CNT_W-1:0] CNT_DIV_WIDE   = CNT_W'(DIV_WIDE_CYC);
  localparam logic [CNT_W-1:0] CNT_DIV_NARROW = CNT_W'(DIV_NARROW_CYC);
  localparam logic [CNT_W-1:0] CNT_MUL_WIDE   = CNT_W'(MUL_WIDE_CYC);
  localparam logic [CNT_W-1:0] CNT_PHASE_BASE = CNT_W'(MUL_WIDE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_ONE        = CNT_W'(1);

  logic                busyQ;
  logic [CNT_W-1:0]    cntQ;
  logic                narrowPendQ;
  logic                isDivQ;
  logic [THREAD_W-1:0] ownerQ;

  logic             accept;
  logic             recircStart;
  logic             lastCycle;
  logic [CNT_W-1:0] startCnt;
  logic [CNT_W-1:0] phaseFull;

  assign accept      = issueValid && !busyQ;
  assign recircStart = accept && (issueIsDiv || issueWide);
  assign lastCycle   = busyQ && (cntQ == CNT_ONE);

  always_comb begin
    if (issueIsDiv) startCnt = issueWide ? CNT_DIV_WIDE : CNT_DIV_NARROW;
    else            startCnt = CNT_MUL_WIDE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ       <= 1'b0;
      cntQ        <= '0;
      narrowPendQ <= 1'b0;
      isDivQ      <= 1'b0;
      ownerQ      <= '0;
    end else begin
      narrowPendQ <= accept && !issueIsDiv && !issueWide;
      if (accept) begin
        ownerQ <= issueThread;
        isDivQ <= issueIsDiv;
        if (recircStart) begin
          busyQ <= 1'b1;
          cntQ  <= startCnt;
        end
      end else if (busyQ) begin
        if (lastCycle) busyQ <= 1'b0;
        cntQ <= cntQ - CNT_ONE;
      end
    end
  end

  assign phaseFull = CNT_PHASE_BASE - cntQ;

  always_comb begin
    strobes               = '0;
    strobes.loadAcc       = accept && !issueIsDiv;
    strobes.loadDivWide   = accept && issueIsDiv && issueWide;
    strobes.loadDivNarrow = accept && issueIsDiv && !issueWide;
    strobes.mulStep       = busyQ && !isDivQ && !lastCycle;
    strobes.divStep       = busyQ && isDivQ && !lastCycle;
    strobes.mulPhase      = phaseFull[1:0];
  end

  assign busy       = busyQ;
  assign issueFlush = issueValid && busyQ;
  assign resValid   = lastCycle || narrowPendQ;
  assign resThread  = ownerQ;
  assign resIsDiv   = isDivQ;

  // R1: a narrow multiply returns next cycle without occupying the unit
  p_narrow_next_r1: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !busyQ && !issueIsDiv && !issueWide |=> resValid && !busyQ);

  // R6: busy only rises after an issue was offered
  p_busy_from_issue_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(issueValid));

  // R6: the result cycle of a recirculation is its last busy cycle
  p_busy_ends_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid && busyQ |=> !busyQ);

  // R5: a colliding issue does not disturb the owner of the unit
  p_flush_keeps_owner_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && issueValid |=> resThread == $past(resThread));

endmodule

// File: rtl/muldiv_dpath.sv
module muldiv_dpath
  import muldiv_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strobes,
  input  logic [WORD_W-1:0]   issueA,
  input  logic [WORD_W-1:0]   issueB,
  input  logic                resIsDiv,
  output logic [WORD_W-1:0]   resData,
  output logic [WORD_W-1:0]   resRem
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] opAQ, opBQ, accQ;
  logic [WORD_W-1:0] quoQ, remQ, divisorQ;

  logic [HALF_W-1:0] mulX, mulY;
  logic [WORD_W-1:0] product;
  logic [WORD_W-1:0] addend;
  logic [2*WORD_W-1:0] stepNext;
  logic [2*WORD_W-1:0] primeNarrow;

  // One restoring step: returns {remainder, quotient shift register}.
  function automatic logic [2*WORD_W-1:0] divStepFn(
    input logic [WORD_W-1:0] rem,
    input logic [WORD_W-1:0] quo,
    input logic [WORD_W-1:0] dsr
  );
    logic [WORD_W:0]   shifted;
    logic [WORD_W:0]   diff;
    logic [WORD_W-1:0] remNext;
    logic              qBit;
    shifted = {rem, quo[WORD_W-1]};
    diff    = shifted - {1'b0, dsr};
    if (!diff[WORD_W]) begin
      remNext = diff[WORD_W-1:0];
      qBit    = 1'b1;
    end else begin
      remNext = shifted[WORD_W-1:0];
      qBit    = 1'b0;
    end
    return {remNext, quo[WORD_W-2:0], qBit};
  endfunction

  // Operand selection for the shared half-width array.
  always_comb begin
    if (strobes.loadAcc) begin
      mulX = issueA[HALF_W-1:0];
      mulY = issueB[HALF_W-1:0];
    end else begin
      case (strobes.mulPhase)
        2'd1:    begin mulX = opAQ[WORD_W-1:HALF_W]; mulY = opBQ[HALF_W-1:0];      end
        2'd2:    begin mulX = opAQ[HALF_W-1:0];      mulY = opBQ[WORD_W-1:HALF_W]; end
        default: begin mulX = opAQ[WORD_W-1:HALF_W]; mulY = opBQ[WORD_W-1:HALF_W]; end
      endcase
    end
  end

  assign product = WORD_W'(mulX) * WORD_W'(mulY);
  // The high-by-high partial product lands entirely above the returned word.
  assign addend  = (strobes.mulPhase == 2'd3) ? '0 : (product << HALF_W);

  assign stepNext    = divStepFn(remQ, quoQ, divisorQ);
  assign primeNarrow = divStepFn('0, {issueA[HALF_W-1:0], {HALF_W{1'b0}}},
                                 WORD_W'(issueB[HALF_W-1:0]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAQ     <= '0;
      opBQ     <= '0;
      accQ     <= '0;
      quoQ     <= '0;
      remQ     <= '0;
      divisorQ <= '0;
    end else begin
      if (strobes.loadAcc) begin
        accQ <= product;
        opAQ <= issueA;
        opBQ <= issueB;
      end else if (strobes.mulStep) begin
        accQ <= accQ + addend;
      end

      if (strobes.loadDivWide) begin
        remQ     <= '0;
        quoQ     <= issueA;
        divisorQ <= issueB;
      end else if (strobes.loadDivNarrow) begin
        {remQ, quoQ} <= primeNarrow;
        divisorQ     <= WORD_W'(issueB[HALF_W-1:0]);
      end else if (strobes.divStep) begin
        {remQ, quoQ} <= stepNext;
      end
    end
  end

  assign resData = resIsDiv ? quoQ : accQ;
  assign resRem  = remQ;

  // R3: restoring division keeps the partial remainder below the divisor
  p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.divStep && (divisorQ != '0) |=> remQ < divisorQ);

  // R7: with a zero divisor every quotient bit produced is a one
  p_zero_div_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.divStep && (divisorQ == '0) |=> quoQ[0]);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int THREAD_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [THREAD_W-1:0] issueThread,
  input  logic                issueIsDiv,
  input  logic                issueWide,
  input  logic [WORD_W-1:0]   issueA,
  input  logic [WORD_W-1:0]   issueB,
  output logic                issueFlush,
  output logic                busy,
  output logic                resValid,
  output logic [THREAD_W-1:0] resThread,
  output logic [WORD_W-1:0]   resData,
  output logic [WORD_W-1:0]   resRem
);

  ctrl_strobes_t strobes;
  logic          resIsDiv;

  muldiv_ctrl #(.WORD_W(WORD_W), .THREAD_W(THREAD_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .issueValid  (issueValid),
    .issueThread (issueThread),
    .issueIsDiv  (issueIsDiv),
    .issueWide   (issueWide),
    .busy        (busy),
    .issueFlush  (issueFlush),
    .resValid    (resValid),
    .resThread   (resThread),
    .resIsDiv    (resIsDiv),
    .strobes     (strobes)
  );

  muldiv_dpath #(.WORD_W(WORD_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .issueA   (issueA),
    .issueB   (issueB),
    .resIsDiv (resIsDiv),
    .resData  (resData),
    .resRem   (resRem)
  );

endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [1:0]  issueThread;
  logic        issueIsDiv;
  logic        issueWide;
  logic [63:0] issueA, issueB;
  logic        issueFlush, busy, resValid;
  logic [1:0]  resThread;
  logic [63:0] resData, resRem;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  muldiv_unit dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueThread(issueThread),
    .issueIsDiv(issueIsDiv), .issueWide(issueWide), .issueA(issueA), .issueB(issueB),
    .issueFlush(issueFlush), .busy(busy), .resValid(resValid),
    .resThread(resThread), .resData(resData), .resRem(resRem)
  );

  function automatic logic [63:0] expMul(input logic wide, input logic [63:0] a, input logic [63:0] b);
    if (wide) return a * b;
    return {32'd0, a[31:0]} * {32'd0, b[31:0]};
  endfunction

  function automatic logic [63:0] expQuo(input logic wide, input logic [63:0] a, input logic [63:0] b);
    if (wide) return (b == 64'd0) ? {64{1'b1}} : a / b;
    if (b[31:0] == 32'd0) return 64'h0000_0000_FFFF_FFFF;
    return {32'd0, a[31:0] / b[31:0]};
  endfunction

  function automatic logic [63:0] expRem(input logic wide, input logic [63:0] a, input logic [63:0] b);
    if (wide) return (b == 64'd0) ? a : a % b;
    if (b[31:0] == 32'd0) return {32'd0, a[31:0]};
    return {32'd0, a[31:0] % b[31:0]};
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Called just after a negedge; returns just after the negedge following the result.
  task automatic runOp(input logic isDiv, input logic wide, input logic [1:0] thr,
                       input logic [63:0] a, input logic [63:0] b, input int collideK);
    int lat;
    bit recirc;
    recirc = isDiv || wide;
    lat = isDiv ? (wide ? 65 : 32) : (wide ? 4 : 1);
    issueValid = 1'b1; issueThread = thr; issueIsDiv = isDiv; issueWide = wide;
    issueA = a; issueB = b;
    #1;
    check(issueFlush == 1'b0, "R10 no flush when idle", 64'(issueFlush), 64'd0);
    @(posedge clk);
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == collideK) begin
        issueValid = 1'b1; issueThread = thr + 2'd1; issueIsDiv = $urandom_range(1, 0) != 0;
        issueWide = $urandom_range(1, 0) != 0;
        issueA = {$urandom, $urandom}; issueB = {$urandom, $urandom};
      end else begin
        issueValid = 1'b0;
      end
      #1;
      check(busy == recirc, "R6 busy during op", 64'(busy), 64'(recirc));
      if (k == collideK)
        check(issueFlush == 1'b1, "R5 collision flushed", 64'(issueFlush), 64'd1);
      else
        check(issueFlush == 1'b0, "R10 no flush without issue", 64'(issueFlush), 64'd0);
      check(resValid == (k == lat), "R1 R2 R3 R4 result strobe timing", 64'(resValid), 64'(k == lat));
      if (k == lat) begin
        check(resThread == thr, "R8 result thread", 64'(resThread), 64'(thr));
        if (!isDiv) begin
          check(resData == expMul(wide, a, b), wide ? "R2 wide product" : "R1 narrow product",
                resData, expMul(wide, a, b));
        end else begin
          check(resData == expQuo(wide, a, b), wide ? "R3 R7 wide quotient" : "R4 R7 narrow quotient",
                resData, expQuo(wide, a, b));
          check(resRem == expRem(wide, a, b), wide ? "R3 R7 wide remainder" : "R4 R7 narrow remainder",
                resRem, expRem(wide, a, b));
        end
      end
    end
    @(negedge clk);
    issueValid = 1'b0;
    #1;
    check(busy == 1'b0, "R6 busy released", 64'(busy), 64'd0);
    check(resValid == 1'b0, "R5 no extra result", 64'(resValid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    rstN = 1'b0; issueValid = 1'b0; issueThread = '0; issueIsDiv = 1'b0; issueWide = 1'b0;
    issueA = '0; issueB = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    check(busy == 1'b0, "R9 reset busy", 64'(busy), 64'd0);
    check(resValid == 1'b0, "R9 reset resValid", 64'(resValid), 64'd0);
    check(issueFlush == 1'b0, "R9 reset flush", 64'(issueFlush), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed corner cases
    runOp(1'b0, 1'b0, 2'd1, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, 0); // R1 all-ones low halves
    runOp(1'b0, 1'b0, 2'd2, 64'd7, 64'd9, 0);                                     // R1 back-to-back
    runOp(1'b0, 1'b1, 2'd3, {64{1'b1}}, {64{1'b1}}, 1);                           // R2 R5 collide first cycle
    runOp(1'b0, 1'b1, 2'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 4); // R2 R5 collide last cycle
    runOp(1'b1, 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 65);                  // R3 R5 collide on result cycle
    runOp(1'b1, 1'b1, 2'd2, 64'h8000_0000_0000_0001, 64'd0, 0);                   // R7 wide zero divisor
    runOp(1'b1, 1'b0, 2'd3, 64'hAAAA_AAAA_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000, 0); // R7 narrow zero divisor
    runOp(1'b1, 1'b0, 2'd0, 64'h5555_5555_0000_0064, 64'h9999_9999_0000_0007, 1); // R4 upper bits ignored
    runOp(1'b1, 1'b1, 2'd1, 64'd5, 64'd9, 0);                                     // R3 dividend below divisor
    runOp(1'b1, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFE, {64{1'b1}}, 0);              // R3 near-max operands

    // Constrained random mix
    for (int n = 0; n < 60; n++) begin
      logic isDiv, wide;
      logic [63:0] a, b;
      int lat, ck;
      isDiv = $urandom_range(1, 0) != 0;
      wide  = $urandom_range(1, 0) != 0;
      a = {$urandom, $urandom};
      b = ($urandom_range(7, 0) == 0) ? {32'd0, $urandom_range(15, 0)} : {$urandom, $urandom};
      if (isDiv && ($urandom_range(3, 0) == 0)) b = b >> $urandom_range(60, 20);
      lat = isDiv ? (wide ? 65 : 32) : (wide ? 4 : 1);
      ck = ((isDiv || wide) && ($urandom_range(2, 0) == 0)) ? $urandom_range(lat, 1) : 0;
      runOp(isDiv, wide, 2'($urandom_range(3, 0)), a, b, ck);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule